// File: doc/BRIEF.md
# Gated Frequency Counter with Overflow Alarm

This block measures the frequency of a conditioned square-wave signal. It counts the signal's rising edges during a window that lasts exactly one period of a 1 Hz reference strobe. Both asynchronous inputs are first brought into the system clock domain, and each of their rising edges becomes a single-cycle event.

A controller opens the window on one reference edge and closes it on the next, but only while `start` is held high. When the window closes, the event count is copied into a result register. That result stays steady until the following window closes, so a downstream display does not flicker. A convert-enable output follows the previous window state and is high during the second in which the latched value is converted for display.

The counter is one bit wider than the result. A count above the result range raises an alarm, and the reported value is then forced to zero.

Top module: `freq_meter`

## Requirements
- R1: With `start` high, each rising edge of `refIn` toggles `gate`, so the window opens on one reference edge and closes on the next. The toggle is visible after the third rising clock edge following the input change and not after the second.
- R2: While `start` is low, reference edges change neither `gate` nor `convertEn`.
- R3: While `rst` is high, `gate`, `convertEn`, `alarm` and `count` are all 0.
- R4: On every reference edge taken while `start` is high, `convertEn` takes the value `gate` had before that edge. It is therefore 0 after a window opens and 1 after it closes.
- R5: The counter restarts from zero when a window opens. When the window closes, `count` shows the number of `testIn` rising edges seen during the window, for totals from 0 to 1023.
- R6: If more than 1023 edges arrive in one window, `alarm` is 1 and `count` is 0 after the close. The next window holding 1023 edges or fewer clears `alarm`.
- R7: `count` and `alarm` change only when a window closes (or on reset). Test edges that arrive while the window is closed, and reference edges while `start` is low, leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Enables window sequencing |
| testIn | input | 1 | Conditioned square wave to measure (asynchronous) |
| refIn | input | 1 | 1 Hz reference strobe (asynchronous) |
| count | output | 10 | Latched edge count of the last window |
| alarm | output | 1 | Overflow of the last window |
| gate | output | 1 | Counting window open |
| convertEn | output | 1 | Convert enable for the downstream converter |

## Verification
Every result depends on a reference edge passing through two synchroniser flops and an edge-detect flop, so `gate`, `convertEn`, `count` and `alarm` update on the third rising clock edge after `refIn` rises. The bench drives each input change on a falling clock edge and samples the outputs on falling edges. At each reference edge it checks that nothing has moved by the second falling edge and that everything has settled by the third. Test pulses are two cycles high and two cycles low, and all of them are finished before the closing reference edge. As a result, the expected count is exactly the number of pulses the bench issued.

// File: rtl/freq_pkg.sv
package freq_pkg;
  typedef struct packed {
    logic clearCnt;     // restart the event counter
    logic clearResult;  // drop the shown value and alarm
    logic countEn;      // window open, events may be counted
    logic latchResult;  // window closing, capture the count
  } ctrlStrobes_t;
endpackage

// File: rtl/freq_edge_sync.sv
module freq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic risePulse
);
  localparam int PIPE_W = STAGES + 1;

  logic [PIPE_W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[PIPE_W-2:0], asyncIn};
  end

  // newest synchronised sample high, previous one low
  assign risePulse = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/freq_ctrl.sv
module freq_ctrl
  import freq_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         refPulse,
  output logic         gate,
  output logic         convertEn,
  output ctrlStrobes_t strobes
);
  logic endMeasure;
  logic stepWin;

  assign stepWin = refPulse & start;

  always_ff @(posedge clk) begin
    if (rst) endMeasure <= 1'b1;
    else     endMeasure <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate      <= 1'b0;
      convertEn <= 1'b0;
    end else if (stepWin) begin
      gate      <= ~gate;
      convertEn <= gate;
    end
  end

  always_comb begin
    strobes.clearCnt    = endMeasure | (stepWin & ~gate);
    strobes.clearResult = endMeasure;
    strobes.latchResult = stepWin & gate;
    strobes.countEn     = gate & ~(stepWin & gate);
  end
endmodule

// File: rtl/freq_datapath.sv
module freq_datapath
  import freq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic             testPulse,
  output logic [RES_W-1:0] count,
  output logic             alarm
);
  localparam int CNT_W = RES_W + 1;

  logic [CNT_W-1:0] evCnt;
  logic             ovf;

  assign ovf = evCnt[CNT_W-1];

  // top bit saturates: once set it stays until the next clear
  always_ff @(posedge clk) begin
    if (rst)                                       evCnt <= '0;
    else if (strobes.clearCnt)                     evCnt <= '0;
    else if (strobes.countEn && testPulse && !ovf) evCnt <= evCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.clearResult) begin
      count <= '0;
      alarm <= 1'b0;
    end else if (strobes.latchResult) begin
      alarm <= ovf;
      count <= ovf ? '0 : evCnt[RES_W-1:0];
    end
  end
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import freq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             testIn,
  input  logic             refIn,
  output logic [RES_W-1:0] count,
  output logic             alarm,
  output logic             gate,
  output logic             convertEn
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] pulses;
  ctrlStrobes_t    strobes;

  assign rawIn = {refIn, testIn};

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_sync
      freq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .asyncIn  (rawIn[i]),
        .risePulse(pulses[i])
      );
    end
  endgenerate

  freq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .refPulse (pulses[1]),
    .gate     (gate),
    .convertEn(convertEn),
    .strobes  (strobes)
  );

  freq_datapath #(.RES_W(RES_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .testPulse(pulses[0]),
    .count    (count),
    .alarm    (alarm)
  );
endmodule

// File: rtl/freq_meter_chk.sv
module freq_meter_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [RES_W-1:0] count,
  input logic             alarm,
  input logic             gate,
  input logic             convertEn
);
  logic rstSeen = 1'b0;

  always @(posedge clk) rstSeen <= rst;

  always @(negedge clk) begin
    if (rstSeen) begin
      AST_RESET_CLEAR: assert (!gate && !convertEn && !alarm && count == '0); // R3
    end
  end

  AST_GATE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(gate) |-> $past(start)); // R2

  AST_CONV_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(convertEn) |-> $past(start)); // R2

  AST_CONV_FOLLOWS_GATE: assert property (@(posedge clk) disable iff (rst)
    !$stable(gate) |-> convertEn == $past(gate)); // R4

  AST_ALARM_ZERO: assert property (@(posedge clk) disable iff (rst)
    alarm |-> count == '0); // R6

  AST_COUNT_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(count) |-> $fell(gate)); // R7

  AST_ALARM_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(alarm) |-> $fell(gate)); // R7
endmodule

bind freq_meter freq_meter_chk #(.RES_W(RES_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .count    (count),
  .alarm    (alarm),
  .gate     (gate),
  .convertEn(convertEn)
);

// File: tb/freq_meter_test.sv
`timescale 1ns/1ps
module freq_meter_test;
  localparam int RES_W = 10;
  localparam int MAXV  = (1 << RES_W) - 1;

  logic clk = 1'b0;
  logic rst, start, testIn, refIn;
  logic [RES_W-1:0] count;
  logic alarm, gate, convertEn;

  int checks = 0;
  int errors = 0;
  int expCount = 0;
  int expAlarm = 0;

  always #2.5 clk = ~clk;

  freq_meter #(.RES_W(RES_W)) uut (
    .clk(clk), .rst(rst), .start(start), .testIn(testIn), .refIn(refIn),
    .count(count), .alarm(alarm), .gate(gate), .convertEn(convertEn)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one reference edge; checks the three-cycle latency of the gate (R1)
  task automatic refEdge(input bit expToggle);
    int g0;
    g0 = gate;
    refIn = 1'b1;
    waitNeg(2);
    check("R1 gate before third clock", gate, g0);
    waitNeg(1);
    check("R1 gate after third clock", gate, expToggle ? 1 - g0 : g0);
    refIn = 1'b0;
    waitNeg(3);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      testIn = 1'b1;
      waitNeg(2);
      testIn = 1'b0;
      waitNeg(2);
    end
  endtask

  task automatic measure(input int n);
    start = 1'b1;
    refEdge(1'b1);
    check("R1 gate open", gate, 1);
    check("R4 convertEn after open", convertEn, 0);
    check("R7 count held while open", count, expCount);
    pulses(n);
    check("R7 count held before close", count, expCount);
    check("R7 alarm held before close", alarm, expAlarm);
    refEdge(1'b1);
    expAlarm = (n > MAXV) ? 1 : 0;
    expCount = (n > MAXV) ? 0 : n;
    check("R1 gate closed", gate, 0);
    check("R4 convertEn after close", convertEn, 1);
    check(n > MAXV ? "R6 count forced zero" : "R5 count", count, expCount);
    check("R6 alarm", alarm, expAlarm);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; testIn = 1'b0; refIn = 1'b0;
    waitNeg(4);
    check("R3 gate in reset", gate, 0);
    check("R3 convertEn in reset", convertEn, 0);
    check("R3 count in reset", count, 0);
    check("R3 alarm in reset", alarm, 0);
    rst = 1'b0;
    waitNeg(2);

    // R2: reference edges without start do nothing
    refEdge(1'b0);
    check("R2 gate idle", gate, 0);
    check("R2 convertEn idle", convertEn, 0);

    // R5: near-exhaustive sweep of small counts
    for (int n = 0; n <= 20; n++) measure(n);
    measure(500);

    // R7: closed window ignores test edges and idle reference edges
    start = 1'b0;
    pulses(6);
    refEdge(1'b0);
    pulses(3);
    refEdge(1'b0);
    check("R7 count ignores closed-window edges", count, expCount);
    check("R2 convertEn held without start", convertEn, 1);
    check("R2 gate held without start", gate, 0);

    // R5/R6: range boundary
    measure(MAXV - 1);
    measure(MAXV);
    measure(MAXV + 1);
    measure(MAXV + 2);
    // R6: alarm clears on next in-range window
    measure(7);
    measure(1500);
    measure(MAXV);

    // R3: reset in the middle of an open window
    measure(9);
    start = 1'b1;
    refEdge(1'b1);
    pulses(4);
    rst = 1'b1;
    waitNeg(2);
    check("R3 gate cleared mid-window", gate, 0);
    check("R3 convertEn cleared mid-window", convertEn, 0);
    check("R3 count cleared mid-window", count, 0);
    check("R3 alarm cleared mid-window", alarm, 0);
    rst = 1'b0;
    waitNeg(2);
    expCount = 0;
    expAlarm = 0;
    measure(33);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule